// File: doc/BRIEF.md
# Packed SIMD Integer Add/Subtract Unit

This block adds or subtracts two integer vectors whose 64 bits are split into equal lanes of 8, 16, 32 or 64 bits. Every lane is an independent adder: no carry or borrow crosses from one lane into the next, and no per-lane carry or overflow flag is reported. A caller that needs the carry uses the long shape, which writes a result of twice the source width.

One datapath serves four arithmetic modifiers and three shapes. The modifiers are plain wrap-around, saturating, halving and rounding-halving. The shapes are same width, long (both operands promoted) and wide (first operand already double width, second promoted). A saturating operation that clamps any lane sets a sticky flag, and the flag stays set until a clear strobe arrives. Combinations the datapath does not support are refused: they leave all state as it was and raise a one-cycle error pulse.

Top module: `simd_addsub`

## Requirements
- R1: `lane_sel` picks the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). Lane i of the same-shape operation uses bits [i*W +: W] of `opa` and `opb`, and no carry or borrow passes between lanes.
- R2: With `mode` = 0 (plain) and `shape` = 0, each lane gives (a + b) mod 2^W, or (a - b) mod 2^W when `is_sub` = 1. For example, 16-bit unsigned lanes 0x1001+0x0FF0, 0x1234+0x5678 and 0x0007+0xFFF8 give 0x1FF1, 0x68AC and 0xFFFF.
- R3: With `mode` = 1 (saturating), a lane result outside its type's range is clamped. Signed (`is_signed` = 1) lanes clamp to [-2^(W-1), 2^(W-1)-1]. An unsigned sum clamps to 2^W-1, and an unsigned difference clamps to 0.
- R4: `sat_flag` rises in the cycle that a saturating result with at least one clamped lane is written. It then stays set until `sat_clear` is pulsed. When both happen in the same cycle, the clear wins.
- R5: With `mode` = 2 (halving), each lane returns the exact sum or difference shifted right by one, rounded toward minus infinity, with no overflow.
- R6: With `mode` = 3 (rounding halving), each lane returns (a ± b + 1) shifted right by one.
- R7: With `shape` = 1 (long), source lanes of W bits (W = 8, 16 or 32) in `opa`[63:0] and `opb` are sign- or zero-extended to 2W bits. Result lane i occupies bits [2W*i +: 2W] of the 128-bit result.
- R8: With `shape` = 2 (wide), the first operand lane is the 2W-bit field `opa`[2W*i +: 2W], and only `opb` lane i is extended. The result has the same layout as in the long shape.
- R9: The result appears on `res_q`, with `res_valid` high for one cycle, on the clock edge after the edge that samples `in_valid`. A same-shape result has bits [127:64] at zero.
- R10: An illegal request is ignored: `res_q`, `res_valid` and the flag are left as they were, and `bad_combo` pulses for one cycle. Illegal means `shape` = 3, or long/wide combined with `mode` ≠ 0, or long/wide combined with 64-bit lanes.
- R11: After reset `res_q`, `res_valid`, `sat_flag` and `bad_combo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| opa | input | 128 | First operand (upper half used by the wide shape only) |
| opb | input | 64 | Second operand |
| lane_sel | input | 2 | Lane width select |
| is_signed | input | 1 | 1 = signed lanes, 0 = unsigned |
| is_sub | input | 1 | 1 = subtract, 0 = add |
| mode | input | 2 | 0 plain, 1 saturate, 2 halve, 3 round-halve |
| shape | input | 2 | 0 same, 1 long, 2 wide, 3 reserved |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| res_q | output | 128 | Registered result vector |
| res_valid | output | 1 | Result written this cycle |
| sat_flag | output | 1 | Sticky saturation flag |
| bad_combo | output | 1 | Pulse for a refused request |

## Verification
The bench aims at carry isolation by adding all-ones to one in every 8-bit lane. A design that leaks carries turns that zero result into a nonzero one. It drives the signed and unsigned saturation edges, both above and below the range; a wrong range check lets a wrapped value through or clamps to the wrong end. Negative halving and rounding operands expose a logical shift where an arithmetic one is needed, and a missing rounding increment. Long and wide cases with signed negative lanes catch a design that zero-extends where it should sign-extend. Finally, refused requests and a clear that collides with a new clamp show whether stale state is overwritten or the flag priority is reversed.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

    typedef enum logic [1:0] {
        MOD_PLAIN = 2'd0,
        MOD_SAT   = 2'd1,
        MOD_HALF  = 2'd2,
        MOD_RHALF = 2'd3
    } mod_e;

    typedef enum logic [1:0] {
        SHP_SAME = 2'd0,
        SHP_LONG = 2'd1,
        SHP_WIDE = 2'd2,
        SHP_RSVD = 2'd3
    } shp_e;

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
    import simd_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn,
    input  logic         sub,
    input  logic [1:0]   mode,
    output logic [W-1:0] y,
    output logic         clamp
);
    localparam int EW = W + 2;
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    mod_e           md;
    logic [EW-1:0]  ea, eb, sum;
    logic           in_rng, over, under;

    always_comb begin
        md    = mod_e'(mode);
        ea    = {{2{sgn & a[W-1]}}, a};
        eb    = {{2{sgn & b[W-1]}}, b};
        sum   = sub ? (ea - eb) : (ea + eb);
        sum   = sum + {{(EW-1){1'b0}}, (md == MOD_RHALF)};
        if (sgn) begin
            in_rng = (&sum[EW-1:W-1]) | ~(|sum[EW-1:W-1]);
        end else begin
            in_rng = ~(|sum[EW-1:W]);
        end
        over  = !in_rng && !sum[EW-1];
        under = !in_rng &&  sum[EW-1];
        clamp = 1'b0;
        case (md)
            MOD_SAT: begin
                clamp = over | under;
                if (over) begin
                    y = sgn ? SMAX : {W{1'b1}};
                end else if (under) begin
                    y = sgn ? SMIN : {W{1'b0}};
                end else begin
                    y = sum[W-1:0];
                end
            end
            MOD_HALF, MOD_RHALF: y = sum[W:1];
            default:             y = sum[W-1:0];
        endcase
    end

endmodule

// File: rtl/simd_lane_promo.sv
module simd_lane_promo #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] a_dbl,
    input  logic [W-1:0]   a_sgl,
    input  logic [W-1:0]   b,
    input  logic           wide,
    input  logic           sgn,
    input  logic           sub,
    output logic [2*W-1:0] y
);
    logic [2*W-1:0] ea, eb;

    always_comb begin
        ea = wide ? a_dbl : {{W{sgn & a_sgl[W-1]}}, a_sgl};
        eb = {{W{sgn & b[W-1]}}, b};
        y  = sub ? (ea - eb) : (ea + eb);
    end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int DW       = 64,
    parameter int MIN_LANE = 8,
    localparam int LW      = 2 * DW,
    localparam int NSZ     = $clog2(DW / MIN_LANE) + 1,
    localparam int SELW    = (NSZ > 1) ? $clog2(NSZ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [LW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [SELW-1:0] lane_sel,
    input  logic            is_signed,
    input  logic            is_sub,
    input  logic [1:0]      mode,
    input  logic [1:0]      shape,
    input  logic            sat_clear,
    output logic [LW-1:0]   res_q,
    output logic            res_valid,
    output logic            sat_flag,
    output logic            bad_combo
);
    typedef struct packed {
        logic [LW-1:0] res;
        logic          vld;
        logic          sat;
        logic          bad;
    } st_t;

    st_t st_d, st_q;

    logic [DW-1:0] norm_y   [NSZ];
    logic [NSZ-1:0] norm_hit;
    logic [LW-1:0] promo_y  [NSZ];

    // same-width lanes: one bank of lane adders per lane size
    for (genvar k = 0; k < NSZ; k++) begin : g_norm
        localparam int W = MIN_LANE << k;
        localparam int N = DW / W;
        logic [DW-1:0] y;
        logic [N-1:0]  hit;
        for (genvar i = 0; i < N; i++) begin : g_lane
            simd_lane_arith #(.W(W)) u_lane (
                .a     (opa[i*W +: W]),
                .b     (opb[i*W +: W]),
                .sgn   (is_signed),
                .sub   (is_sub),
                .mode  (mode),
                .y     (y[i*W +: W]),
                .clamp (hit[i])
            );
        end
        assign norm_y[k]   = y;
        assign norm_hit[k] = |hit;
    end

    // promoting lanes: long / wide, every size except the full-width one
    for (genvar k = 0; k < NSZ - 1; k++) begin : g_promo
        localparam int W = MIN_LANE << k;
        localparam int N = DW / W;
        logic [LW-1:0] y;
        for (genvar i = 0; i < N; i++) begin : g_lane
            simd_lane_promo #(.W(W)) u_lane (
                .a_dbl (opa[2*W*i +: 2*W]),
                .a_sgl (opa[W*i +: W]),
                .b     (opb[W*i +: W]),
                .wide  (shape == SHP_WIDE),
                .sgn   (is_signed),
                .sub   (is_sub),
                .y     (y[2*W*i +: 2*W])
            );
        end
        assign promo_y[k] = y;
    end
    assign promo_y[NSZ-1] = '0;

    logic illegal;
    logic sel_full;

    always_comb begin
        sel_full = (lane_sel == SELW'(NSZ - 1));
        illegal  = (shp_e'(shape) == SHP_RSVD) ||
                   ((shp_e'(shape) != SHP_SAME) &&
                    ((mod_e'(mode) != MOD_PLAIN) || sel_full));

        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.bad = 1'b0;
        if (in_valid) begin
            if (illegal) begin
                st_d.bad = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                if (shp_e'(shape) == SHP_SAME) begin
                    st_d.res = {{DW{1'b0}}, norm_y[lane_sel]};
                    if ((mod_e'(mode) == MOD_SAT) && norm_hit[lane_sel]) begin
                        st_d.sat = 1'b1;
                    end
                end else begin
                    st_d.res = promo_y[lane_sel];
                end
            end
        end
        if (sat_clear) begin
            st_d.sat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q     = st_q.res;
    assign res_valid = st_q.vld;
    assign sat_flag  = st_q.sat;
    assign bad_combo = st_q.bad;

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
    parameter int DW   = 64,
    parameter int SELW = 2,
    parameter int NSZ  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [SELW-1:0]   lane_sel,
    input logic [1:0]        mode,
    input logic [1:0]        shape,
    input logic              sat_clear,
    input logic [2*DW-1:0]   res_q,
    input logic              res_valid,
    input logic              sat_flag,
    input logic              bad_combo
);
    logic bad_req;
    assign bad_req = (shape == 2'd3) ||
                     ((shape != 2'd0) && ((mode != 2'd0) || (lane_sel == SELW'(NSZ - 1))));

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad_req) |=> (res_valid && !bad_combo)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !bad_combo)); // R9

    AST_SAME_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shape == 2'd0) |=> (res_q[2*DW-1:DW] == '0)); // R9

    AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_req) |=> (bad_combo && !res_valid && $stable(res_q))); // R10

    AST_REFUSED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_req && !sat_flag) |=> !sat_flag); // R10

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sat_clear |=> !sat_flag); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag); // R4

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(in_valid && mode == 2'd1 && shape == 2'd0)); // R3

endmodule

bind simd_addsub simd_addsub_chk #(.DW(DW), .SELW(SELW), .NSZ(NSZ)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lane_sel  (lane_sel),
    .mode      (mode),
    .shape     (shape),
    .sat_clear (sat_clear),
    .res_q     (res_q),
    .res_valid (res_valid),
    .sat_flag  (sat_flag),
    .bad_combo (bad_combo)
);

// File: tb/test_simd_addsub.sv
module test_simd_addsub;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0;
    logic [63:0]  opb = '0;
    logic [1:0]   lane_sel = '0;
    logic         is_signed = 1'b0;
    logic         is_sub = 1'b0;
    logic [1:0]   mode = '0;
    logic [1:0]   shape = '0;
    logic         sat_clear = 1'b0;
    logic [127:0] res_q;
    logic         res_valid;
    logic         sat_flag;
    logic         bad_combo;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_res = '0;
    bit           exp_flag = 1'b0;

    always #2 clk = ~clk;

    simd_addsub i_simd_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .lane_sel(lane_sel), .is_signed(is_signed), .is_sub(is_sub), .mode(mode),
        .shape(shape), .sat_clear(sat_clear), .res_q(res_q), .res_valid(res_valid),
        .sat_flag(sat_flag), .bad_combo(bad_combo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [66:0] ext67(input logic [127:0] v, input int w, input bit sg);
        logic [66:0] r;
        for (int b = 0; b < 67; b++) r[b] = (b < w) ? v[b] : (sg & v[w-1]);
        return r;
    endfunction

    function automatic logic [127:0] lmask(input int w);
        return (128'(1) << w) - 128'(1);
    endfunction

    function automatic bit is_bad(input logic [1:0] shp, input logic [1:0] md, input logic [1:0] ls);
        return (shp == 2'd3) || ((shp != 2'd0) && ((md != 2'd0) || (ls == 2'd3)));
    endfunction

    task automatic ref_calc(input logic [127:0] a, input logic [63:0] b, input logic [1:0] ls,
                            input bit sg, input bit sb, input logic [1:0] md, input logic [1:0] shp,
                            output logic [127:0] r, output bit hit);
        int w;
        logic [66:0] ea, eb, s, y, hi, lo;
        w = 8 << ls;
        r = '0;
        hit = 1'b0;
        for (int i = 0; i < 64 / w; i++) begin
            if (shp == 2'd0) begin
                ea = ext67(a >> (w * i), w, sg);
                eb = ext67({64'd0, b} >> (w * i), w, sg);
                s  = sb ? ea - eb : ea + eb;
                if (md == 2'd3) s = s + 67'd1;
                hi = sg ? (67'(1) << (w - 1)) - 67'd1 : (67'(1) << w) - 67'd1;
                lo = sg ? -(67'(1) << (w - 1)) : 67'd0;
                y  = s;
                if (md == 2'd1) begin
                    if ($signed(s) > $signed(hi)) begin y = hi; hit = 1'b1; end
                    else if ($signed(s) < $signed(lo)) begin y = lo; hit = 1'b1; end
                end else if (md >= 2'd2) begin
                    y = s >> 1;
                end
                r = r | ((128'(y) & lmask(w)) << (w * i));
            end else begin
                ea = (shp == 2'd2) ? ext67(a >> (2 * w * i), 2 * w, sg) : ext67(a >> (w * i), w, sg);
                eb = ext67({64'd0, b} >> (w * i), w, sg);
                s  = sb ? ea - eb : ea + eb;
                r = r | ((128'(s) & lmask(2 * w)) << (2 * w * i));
            end
        end
    endtask

    task automatic run_op(input string req, input logic [127:0] a, input logic [63:0] b,
                          input logic [1:0] ls, input bit sg, input bit sb, input logic [1:0] md,
                          input logic [1:0] shp, input bit clr);
        logic [127:0] r;
        bit hit, bad;
        @(negedge clk);
        opa = a; opb = b; lane_sel = ls; is_signed = sg; is_sub = sb;
        mode = md; shape = shp; sat_clear = clr; in_valid = 1'b1;
        bad = is_bad(shp, md, ls);
        ref_calc(a, b, ls, sg, sb, md, shp, r, hit);
        if (!bad) exp_res = r;
        if (clr) exp_flag = 1'b0;
        else if (!bad && hit && md == 2'd1) exp_flag = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; sat_clear = 1'b0;
        chk(res_valid == !bad, req, "res_valid", 128'(res_valid), 128'(!bad));
        chk(bad_combo == bad, req, "bad_combo", 128'(bad_combo), 128'(bad));
        chk(res_q == exp_res, req, "res_q", res_q, exp_res);
        chk(sat_flag == exp_flag, req, "sat_flag", 128'(sat_flag), 128'(exp_flag));
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        chk(res_q == '0, "R11", "res_q", res_q, '0);
        chk(!res_valid && !sat_flag && !bad_combo, "R11", "status",
            {125'd0, res_valid, sat_flag, bad_combo}, '0);
        rst_n = 1'b1;

        // R2: 16-bit unsigned example lanes
        run_op("R2", {64'd0, 64'h1001_1234_0007_00AB}, 64'h0FF0_5678_FFF8_00CD, 2'd1, 0, 0, 2'd0, 2'd0, 0);
        chk(res_q == 128'h1FF1_68AC_FFFF_0178, "R2", "example", res_q, 128'h1FF1_68AC_FFFF_0178);
        // R1: carry isolation in 8-bit lanes
        run_op("R1", {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 64'h0101_0101_0101_0101, 2'd0, 0, 0, 2'd0, 2'd0, 0);
        chk(res_q == '0, "R1", "isolation", res_q, '0);
        // R3: signed high clamp, then unsigned add/sub clamps
        run_op("R3", {64'd0, 64'h0000_0000_0000_007F}, 64'h01, 2'd0, 1, 0, 2'd1, 2'd0, 0);
        chk(res_q[7:0] == 8'h7F, "R3", "signed max", res_q, 128'h7F);
        run_op("R3", {64'd0, 64'h80}, 64'h01, 2'd0, 1, 1, 2'd1, 2'd0, 0);
        chk(res_q[7:0] == 8'h80, "R3", "signed min", res_q, 128'h80);
        run_op("R3", {64'd0, 64'hFFF0}, 64'h0020, 2'd1, 0, 0, 2'd1, 2'd0, 0);
        run_op("R3", {64'd0, 64'h0005}, 64'h0009, 2'd2, 0, 1, 2'd1, 2'd0, 0);
        // R4: clear colliding with a new clamp, then sticky hold
        run_op("R4", {64'd0, 64'h7F}, 64'h01, 2'd0, 1, 0, 2'd1, 2'd0, 1);
        run_op("R4", {64'd0, 64'h7F}, 64'h01, 2'd0, 1, 0, 2'd1, 2'd0, 0);
        run_op("R4", {64'd0, 64'h10}, 64'h01, 2'd0, 1, 0, 2'd0, 2'd0, 0);
        // R5/R6: negative halving and rounding
        run_op("R5", {64'd0, 64'hFF}, 64'hFE, 2'd0, 1, 0, 2'd2, 2'd0, 0);
        chk(res_q[7:0] == 8'hFE, "R5", "floor", res_q, 128'hFE);
        run_op("R6", {64'd0, 64'hFF}, 64'hFE, 2'd0, 1, 0, 2'd3, 2'd0, 0);
        chk(res_q[7:0] == 8'hFF, "R6", "round", res_q, 128'hFF);
        run_op("R5", {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 0, 2'd2, 2'd0, 0);
        // R7/R8: long and wide
        run_op("R7", {64'd0, 64'hFF}, 64'hFF, 2'd0, 0, 0, 2'd0, 2'd1, 0);
        chk(res_q[15:0] == 16'h01FE, "R7", "long", res_q, 128'h01FE);
        run_op("R7", {64'd0, 64'h8000_0000}, 64'h8000_0000, 2'd2, 1, 0, 2'd0, 2'd1, 0);
        run_op("R8", {64'd0, 64'h0100}, 64'h80, 2'd0, 1, 0, 2'd0, 2'd2, 0);
        chk(res_q[15:0] == 16'h0080, "R8", "wide", res_q, 128'h0080);
        // R10: refused requests
        run_op("R10", {64'd0, 64'h55}, 64'h11, 2'd0, 0, 0, 2'd1, 2'd1, 0);
        run_op("R10", {64'd0, 64'h55}, 64'h11, 2'd3, 0, 0, 2'd0, 2'd2, 0);
        run_op("R10", {64'd0, 64'h55}, 64'h11, 2'd1, 0, 0, 2'd0, 2'd3, 0);

        // R9 with R1..R8: random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 600; n++) begin
            logic [1:0] ls, md, shp;
            ls  = 2'($urandom);
            md  = 2'($urandom);
            shp = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
            run_op("R9", {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
                   ls, 1'($urandom), 1'($urandom), md, shp, ($urandom % 10) == 0);
        end

        summary();
        $finish;
    end

endmodule